// File: doc/BRIEF.md
# Wrapping or Linear Burst Address Sequencer

This block produces the word-address stream for one synchronous burst access to an external memory device. A start strobe captures a start word address together with the access configuration. From the cycle after the strobe, the block presents one word address per beat with a one-cycle valid strobe, and then raises a one-cycle done flag.

A group is the aligned set of words whose size equals the burst length. A single wrap-enable control selects what happens at the end of a group. In wrap mode the address returns to the first word of the same group. In linear mode it moves on into the next group. While moving into the next group in linear mode, the block holds its address for as long as the device wait input is high.

A burst is only issued for synchronous accesses that have a page length configured and the matching multiple-access enable set. Every other request becomes a single-word access.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, beatValid and burstDone are low and stay low until a start strobe is accepted.
- R2: A start strobe accepted while idle gives beatValid high on the next cycle with beatAddr equal to startAddr. Without stalls, the following beats appear on consecutive cycles.
- R3: With wrapEn high, the beat after the last word of an aligned group addresses the first word of that same group. The upper address bits never change during the burst (4-word burst from 1 gives 1,2,3,0).
- R4: With wrapEn low, each beat address is the previous one plus one, including across group boundaries (4-word burst from 1 gives 1,2,3,4).
- R5: When startAddr is a multiple of the burst length, wrap and linear modes give the same sequence (4-word burst from 0 gives 0,1,2,3).
- R6: In linear mode, when the next beat would cross into the next group and devWait is high, beatValid stays low and beatAddr holds the last address of the group until devWait is low. In wrap mode devWait has no effect.
- R7: pageLen encodes the burst length as 1 = 4 words, 2 = 8 words, 3 = 16 words. A value of 0 means no page is configured, and the access is a single word.
- R8: A read request (isWrite = 0) bursts only if readMultiEn is high. A write request (isWrite = 1) bursts only if writeMultiEn is high. Otherwise the access is a single word.
- R9: A request with isSync low is always a single-word access, whatever the other settings are.
- R10: burstDone is high for exactly one cycle, on the cycle after the last beat, and never together with beatValid.
- R11: A start strobe that arrives while a burst is in progress, including during a wait stall, is ignored. It produces no extra beats and does not change the addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Request to begin an access |
| startAddr | input | ADDR_W | First word address of the access |
| isWrite | input | 1 | 1 = write request, 0 = read request |
| isSync | input | 1 | 1 = synchronous access |
| wrapEn | input | 1 | 1 = wrap inside the group, 0 = linear |
| readMultiEn | input | 1 | Allows multi-word reads |
| writeMultiEn | input | 1 | Allows multi-word writes |
| pageLen | input | 2 | Burst length code (0 none, 1 = 4, 2 = 8, 3 = 16) |
| devWait | input | 1 | Device wait, honoured on a linear group crossing |
| beatAddr | output | ADDR_W | Word address of the current beat |
| beatValid | output | 1 | One cycle per beat |
| burstDone | output | 1 | One cycle after the last beat |

## Verification
The assertions assume that the configuration inputs are meaningful in the cycle a start strobe is accepted; the block captures them there. They also assume that devWait matters only at a linear group crossing. The driver holds every configuration input steady from the strobe until burstDone, and raises devWait only in the tests that exercise the stall, including one wrap-mode burst where devWait must be ignored. Repeated strobes during a burst are issued on purpose. The scoreboard shows that these strobes add no beats.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
  parameter int MIN_LEN_LOG2 = 2,
  localparam int MASK_W = MIN_LEN_LOG2 + 2
) (
  input  logic [1:0]        pageLen,
  input  logic              isWrite,
  input  logic              isSync,
  input  logic              readMultiEn,
  input  logic              writeMultiEn,
  output logic [MASK_W-1:0] groupMask
);

  logic multiOk;

  // Bursting needs a synchronous access, a page length, and the matching enable.
  assign multiOk = isSync && (pageLen != 2'd0) &&
                   (isWrite ? writeMultiEn : readMultiEn);

  // Code k gives log2(length) = MIN_LEN_LOG2 - 1 + k; the mask is length - 1.
  for (genvar g = 0; g < MASK_W; g++) begin : g_maskBit
    assign groupMask[g] = multiOk && ((int'(pageLen) + MIN_LEN_LOG2 - 1) > g);
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              wrapEn,
  input  logic [MASK_W-1:0] groupMask,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              crossPending
);

  localparam int PAD_W = ADDR_W - MASK_W;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] maskExt;
  logic [ADDR_W-1:0] incAddr;
  logic [MASK_W-1:0] maskR;
  logic              wrapR;

  assign maskExt = {{PAD_W{1'b0}}, maskR};
  assign incAddr = curAddr + ADDR_W'(1);

  always_comb begin
    if (wrapR) nextAddr = (curAddr & ~maskExt) | (incAddr & maskExt);
    else       nextAddr = incAddr;
  end

  // The next step leaves the group only in linear mode at the last word of a group.
  assign crossPending = !wrapR && (maskR != '0) && ((curAddr & maskExt) == maskExt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      maskR   <= '0;
      wrapR   <= 1'b0;
    end else if (strobe.load) begin
      curAddr <= startAddr;
      maskR   <= groupMask;
      wrapR   <= wrapEn;
    end else if (strobe.advance) begin
      curAddr <= nextAddr;
    end
  end

  assign beatAddr = curAddr;

  p_wrap_in_group_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.load && wrapR) |=>
      ((curAddr & ~maskExt) == $past(curAddr & ~maskExt)));

  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.load && !wrapR) |=>
      (curAddr == $past(curAddr) + ADDR_W'(1)));

  p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.advance) |=> $stable(curAddr));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic [MASK_W-1:0] groupMask,
  input  logic              crossPending,
  input  logic              devWait,
  output seqStrobe_t        strobe,
  output logic              beatValid,
  output logic              burstDone
);

  seqState_t         state;
  logic [MASK_W-1:0] beatsLeft;
  logic              moreBeats;
  logic              stallNow;

  assign moreBeats = (state == SEQ_RUN) && (beatsLeft != '0);
  assign stallNow  = crossPending && devWait;

  always_comb begin
    strobe         = '0;
    strobe.load    = startStrobe && (state == SEQ_IDLE);
    strobe.advance = moreBeats && !stallNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      beatsLeft <= '0;
      beatValid <= 1'b0;
      burstDone <= 1'b0;
    end else begin
      beatValid <= 1'b0;
      burstDone <= 1'b0;
      if (strobe.load) begin
        state     <= SEQ_RUN;
        beatsLeft <= groupMask;   // beats - 1 equals the group mask
        beatValid <= 1'b1;
      end else if (state == SEQ_RUN) begin
        if (beatsLeft == '0) begin
          state     <= SEQ_IDLE;
          burstDone <= 1'b1;
        end else if (strobe.advance) begin
          beatsLeft <= beatsLeft - MASK_W'(1);
          beatValid <= 1'b1;
        end
      end
    end
  end

  p_valid_done_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(beatValid && burstDone));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (moreBeats && startStrobe) |=> (state == SEQ_RUN));

  p_wait_stalls_r6: assert property (@(posedge clk) disable iff (!rstN)
    (moreBeats && crossPending && devWait) |=> !beatValid);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int MIN_LEN_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              isWrite,
  input  logic              isSync,
  input  logic              wrapEn,
  input  logic              readMultiEn,
  input  logic              writeMultiEn,
  input  logic [1:0]        pageLen,
  input  logic              devWait,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              beatValid,
  output logic              burstDone
);

  localparam int MASK_W = MIN_LEN_LOG2 + 2;

  seqStrobe_t        strobe;
  logic [MASK_W-1:0] groupMask;
  logic              crossPending;

  burst_len_decode #(.MIN_LEN_LOG2(MIN_LEN_LOG2)) u_decode (
    .pageLen     (pageLen),
    .isWrite     (isWrite),
    .isSync      (isSync),
    .readMultiEn (readMultiEn),
    .writeMultiEn(writeMultiEn),
    .groupMask   (groupMask)
  );

  seq_ctrl #(.MASK_W(MASK_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startStrobe (startStrobe),
    .groupMask   (groupMask),
    .crossPending(crossPending),
    .devWait     (devWait),
    .strobe      (strobe),
    .beatValid   (beatValid),
    .burstDone   (burstDone)
  );

  seq_datapath #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startAddr   (startAddr),
    .wrapEn      (wrapEn),
    .groupMask   (groupMask),
    .beatAddr    (beatAddr),
    .crossPending(crossPending)
  );

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startStrobe = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          isWrite = 1'b0, isSync = 1'b1, wrapEn = 1'b0;
  logic          readMultiEn = 1'b0, writeMultiEn = 1'b0;
  logic [1:0]    pageLen = 2'd0;
  logic          devWait = 1'b0;
  logic [AW-1:0] beatAddr;
  logic          beatValid, burstDone;

  always #2.5 clk = ~clk;   // 200 MHz

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .startAddr(startAddr),
    .isWrite(isWrite), .isSync(isSync), .wrapEn(wrapEn),
    .readMultiEn(readMultiEn), .writeMultiEn(writeMultiEn), .pageLen(pageLen),
    .devWait(devWait), .beatAddr(beatAddr), .beatValid(beatValid),
    .burstDone(burstDone)
  );

  typedef struct {
    logic [AW-1:0] addr;
    bit            isDone;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare each beat and done pulse against the scoreboard queue.
  always @(negedge clk) begin
    if (rstN && (beatValid || burstDone)) begin
      if (beatValid && burstDone)
        check(1'b0, "R10", "valid with done", 1, 0);
      else if (expQ.size() == 0)
        check(1'b0, "R11", "unexpected output (valid/done)", {beatValid, burstDone}, 0);
      else begin
        expItem_t it;
        it = expQ.pop_front();
        check(burstDone == it.isDone, it.tag, "done vs beat", burstDone, it.isDone);
        if (!it.isDone)
          check(beatAddr == it.addr, it.tag, "beat address", beatAddr, it.addr);
      end
    end
  end

  function automatic int beatsFor(input [1:0] pl, input bit w, sy, rm, wm);
    if (pl != 0 && sy && (w ? wm : rm)) return 2 << pl;
    return 1;
  endfunction

  task automatic pushExpected(input logic [AW-1:0] a, input int n, input bit wr,
                              input string tag);
    logic [AW-1:0] m;
    m = AW'(n - 1);
    for (int i = 0; i < n; i++) begin
      expItem_t it;
      it.addr   = wr ? ((a & ~m) | ((a + AW'(i)) & m)) : a + AW'(i);
      it.isDone = 1'b0;
      it.tag    = tag;
      expQ.push_back(it);
    end
    begin
      expItem_t d;
      d.addr = '0; d.isDone = 1'b1; d.tag = tag;
      expQ.push_back(d);
    end
  endtask

  // Driver: configure, push expectations, pulse start, wait for done.
  task automatic runBurst(input logic [AW-1:0] a, input [1:0] pl, input bit wr,
                          input bit w, sy, rm, wm, input string tag,
                          input bit chkLat, input bit extraStart);
    int n, lat;
    n = beatsFor(pl, w, sy, rm, wm);
    pushExpected(a, n, wr, tag);
    @(negedge clk);
    startAddr = a; pageLen = pl; wrapEn = wr; isWrite = w; isSync = sy;
    readMultiEn = rm; writeMultiEn = wm; startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    lat = 1;
    while (!burstDone && lat < 200) begin
      if (extraStart && lat == 2) begin
        startStrobe = 1'b1; startAddr = a + AW'(40);   // R11: ignored
      end else startStrobe = 1'b0;
      @(negedge clk);
      lat++;
    end
    startStrobe = 1'b0;
    if (chkLat) check(lat == n + 1, tag, "R2/R10 cycles to done", lat, n + 1);
    @(negedge clk);
    check(!beatValid && !burstDone, "R10", "idle after done", {beatValid, burstDone}, 0);
    check(expQ.size() == 0, tag, "scoreboard drained", expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!beatValid && !burstDone, "R1", "outputs in reset", {beatValid, burstDone}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!beatValid && !burstDone, "R1", "idle after reset", {beatValid, burstDone}, 0);

    // R5: aligned start, same in both modes; R2 latency
    runBurst(24'h000000, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5", 1'b1, 1'b0);
    runBurst(24'h000000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R5", 1'b1, 1'b0);
    // R3 / R4: unaligned start
    runBurst(24'h000001, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3", 1'b1, 1'b0);
    runBurst(24'h000001, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4", 1'b1, 1'b0);
    // R7: 8 and 16 word lengths, page length zero
    runBurst(24'h00001D, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7", 1'b1, 1'b0);
    runBurst(24'h000105, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7", 1'b1, 1'b0);
    runBurst(24'hABCDE7, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7", 1'b1, 1'b0);
    runBurst(24'h000042, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R7", 1'b1, 1'b0);
    // R8: enables per direction
    runBurst(24'h000011, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R8", 1'b1, 1'b0);
    runBurst(24'h000011, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R8", 1'b1, 1'b0);
    runBurst(24'h000011, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R8", 1'b1, 1'b0);
    // R9: asynchronous requests are single
    runBurst(24'h000022, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R9", 1'b1, 1'b0);
    runBurst(24'h000022, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9", 1'b1, 1'b0);
    // R11: a second strobe mid-burst adds nothing
    runBurst(24'h000031, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R11", 1'b1, 1'b1);
    // R6: wrap mode ignores devWait
    devWait = 1'b1;
    runBurst(24'h000001, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6", 1'b1, 1'b0);

    // R6: linear crossing stalls while devWait is high
    pushExpected(24'h000002, 4, 1'b0, "R6");
    @(negedge clk);
    startAddr = 24'h000002; pageLen = 2'd1; wrapEn = 1'b0; isWrite = 1'b0;
    isSync = 1'b1; readMultiEn = 1'b1; startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    for (int k = 0; k < 10 && !(beatValid && beatAddr == 24'h000003); k++)
      @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!beatValid && beatAddr == 24'h000003, "R6", "hold during wait",
            {beatValid, beatAddr}, 24'h000003);
    end
    devWait = 1'b0;
    for (int k = 0; k < 10 && !burstDone; k++) @(negedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R6", "stall burst drained", expQ.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule